// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog Reset

This block is a word-addressed timer peripheral for an operating system's time base. A 32-bit counter advances by one on every clock cycle in which the tick-enable strobe is high. Software may overwrite the counter at any time, and counting resumes from the value written. Four match channels each hold a 32-bit compare value. When a tick moves the counter onto a channel's compare value and that channel is enabled, the channel's pending flag is set and its interrupt line goes high. The flag and the line stay high until software clears them by writing a 1 to the flag's bit in the status register.

Channel 3 also serves as a watchdog. While the watchdog enable bit is set, a channel 3 match event sends a one-cycle system reset request. This request does not depend on the channel 3 interrupt enable. The register port is a single-cycle write strobe with a combinational read of the addressed word.

Top module: `ostmr_top`

## Requirements
- R1: After a synchronous reset, the counter, the compare values, the status flags, the interrupt enable field and the watchdog enable all read as zero, and `irq` and `wdt_rst_req` are low.
- R2: In a cycle with `tick_en` high and no counter write, the counter increments by one modulo 2^32, so 0xFFFFFFFF is followed by 0. In a cycle with neither, the counter holds its value.
- R3: A write to offset 0x10 loads the counter with `wdata`. Counting continues from the loaded value. A write in the same cycle as a tick takes priority over the tick.
- R4: The compare values of channels 0 to 3 are written and read at offsets 0x00, 0x04, 0x08 and 0x0C.
- R5: A match event on channel i is a tick that moves the counter to a value equal to compare value i. If bit i of the enable register is 1, status bit i and `irq[i]` become 1 at the same clock edge at which the counter takes that value.
- R6: A match event on a channel whose enable bit is 0 sets neither its status bit nor its `irq` line.
- R7: Reading offset 0x14 returns the pending flags, with channel i in bit i. Writing offset 0x14 clears each flag whose `wdata` bit is 1 and drops its `irq` line. Flags whose `wdata` bit is 0 are left unchanged.
- R8: A write to offset 0x1C keeps only `wdata[11:0]`, and a read returns those 12 bits zero-extended. Bits 3:0 enable channels 3:0.
- R9: Offset 0x18 bit 0 is the watchdog enable. A channel 3 match event while it is 1 drives `wdt_rst_req` high for exactly the one cycle after the counter takes the match value. This happens whatever the channel 3 interrupt enable is.
- R10: While the watchdog enable is 0, a channel 3 match event leaves `wdt_rst_req` low.
- R11: A read of an unaligned or undefined offset returns zero. A write to such an offset changes no register.
- R12: Loading the counter with a value equal to a compare value is not a match event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe; counter advances in each cycle it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the accessed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines, one per pending flag |
| wdt_rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
On every cycle, the assertions check that the counter steps, holds and loads as required, and that a pending flag is set by an enabled match and held until a write-one clear. They also check that the watchdog request lasts one cycle and comes only from an enabled channel 3 match. The bench scenarios cover what the assertions cannot: register offsets and read-back values, the 12-bit truncation of the enable field, wrap-around from 0xFFFFFFFF, write priority over a tick in the same cycle, the absence of a match on a counter load, and the fact that writes to undefined offsets leave every register unchanged.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    localparam int unsigned CNT_W    = 32;
    localparam int unsigned NUM_CH   = 4;
    localparam int unsigned IEN_W    = 12;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned WDOG_CH  = 3;
    localparam int unsigned CH_IDX_W = $clog2(NUM_CH);
    localparam int unsigned WORD_W   = ADDR_W - 2;

    // Word indices (byte offset / 4) of the fixed registers
    localparam logic [WORD_W-1:0] WIDX_COUNT  = WORD_W'(8'h10 >> 2);
    localparam logic [WORD_W-1:0] WIDX_STATUS = WORD_W'(8'h14 >> 2);
    localparam logic [WORD_W-1:0] WIDX_WDOG   = WORD_W'(8'h18 >> 2);
    localparam logic [WORD_W-1:0] WIDX_IEN    = WORD_W'(8'h1C >> 2);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_WDOG,
        SEL_IEN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e              sel;
        logic [CH_IDX_W-1:0]   ch;
    } reg_decode_t;

    function automatic reg_decode_t decode_offset(input logic [ADDR_W-1:0] a);
        reg_decode_t        d;
        logic [WORD_W-1:0]  w;
        w     = a[ADDR_W-1:2];
        d.sel = SEL_NONE;
        d.ch  = a[2 +: CH_IDX_W];
        if (a[1:0] == 2'b00) begin
            if (w < WORD_W'(NUM_CH))   d.sel = SEL_MATCH;
            else if (w == WIDX_COUNT)  d.sel = SEL_COUNT;
            else if (w == WIDX_STATUS) d.sel = SEL_STATUS;
            else if (w == WIDX_WDOG)   d.sel = SEL_WDOG;
            else if (w == WIDX_IEN)    d.sel = SEL_IEN;
        end
        return d;
    endfunction

endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter
    import ostmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             adv
);

    assign cnt_inc = cnt + CNT_W'(1);
    assign adv     = tick_en && !load;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (adv)  cnt <= cnt_inc;
    end

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !load) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !load) |=> $stable(cnt));

    p_count_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/ostmr_channel.sv
module ostmr_channel
    import ostmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             match_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic             ien,
    input  logic             clr_wr,
    input  logic             clr_bit,
    output logic [CNT_W-1:0] match_val,
    output logic             hit,
    output logic             flag
);

    logic set_flag;
    logic clr_flag;

    // A match event only comes from a tick, never from a counter load
    assign hit      = adv && (cnt_inc == match_val);
    assign set_flag = hit && ien;
    assign clr_flag = clr_wr && clr_bit;

    always_ff @(posedge clk) begin
        if (rst)           match_val <= '0;
        else if (match_wr) match_val <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (set_flag) flag <= 1'b1;
        else if (clr_flag) flag <= 1'b0;
    end

    p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && ien) |=> flag);

    p_flag_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(hit && ien)) |=> !flag);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !(clr_wr && clr_bit)) |=> flag);

endmodule

// File: rtl/ostmr_ctrl.sv
module ostmr_ctrl
    import ostmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ien_wr,
    input  logic [IEN_W-1:0] ien_wdata,
    input  logic             wdog_wr,
    input  logic             wdog_wdata,
    input  logic             wdog_hit,
    output logic [IEN_W-1:0] ien,
    output logic             wdog_en,
    output logic             wdt_rst_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien     <= '0;
            wdog_en <= 1'b0;
        end else begin
            if (ien_wr)  ien     <= ien_wdata;
            if (wdog_wr) wdog_en <= wdog_wdata;
        end
    end

    // Independent of the channel interrupt enable
    always_ff @(posedge clk) begin
        if (rst) wdt_rst_req <= 1'b0;
        else     wdt_rst_req <= wdog_hit && wdog_en;
    end

    p_wdt_single_r9: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |=> !wdt_rst_req);

    p_wdt_fire_r9: assert property (@(posedge clk) disable iff (rst)
        (wdog_hit && wdog_en) |=> wdt_rst_req);

    p_wdt_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!wdog_en || !wdog_hit) |=> !wdt_rst_req);

endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_CH-1:0] irq,
    output logic              wdt_rst_req
);

    reg_decode_t       dec;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_inc;
    logic              adv;
    logic [IEN_W-1:0]  ien;
    logic              wdog_en;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] flag;
    logic [CNT_W-1:0]  match_val [NUM_CH];
    logic              wr_count;
    logic              wr_status;

    assign dec       = decode_offset(addr);
    assign wr_count  = wr_en && (dec.sel == SEL_COUNT);
    assign wr_status = wr_en && (dec.sel == SEL_STATUS);

    ostmr_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (wr_count),
        .load_val (wdata),
        .cnt      (cnt),
        .cnt_inc  (cnt_inc),
        .adv      (adv)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic mwr;
        assign mwr = wr_en && (dec.sel == SEL_MATCH) && (dec.ch == CH_IDX_W'(i));

        ostmr_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .match_wr  (mwr),
            .wdata     (wdata),
            .adv       (adv),
            .cnt_inc   (cnt_inc),
            .ien       (ien[i]),
            .clr_wr    (wr_status),
            .clr_bit   (wdata[i]),
            .match_val (match_val[i]),
            .hit       (hit[i]),
            .flag      (flag[i])
        );
    end

    ostmr_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ien_wr      (wr_en && (dec.sel == SEL_IEN)),
        .ien_wdata   (wdata[IEN_W-1:0]),
        .wdog_wr     (wr_en && (dec.sel == SEL_WDOG)),
        .wdog_wdata  (wdata[0]),
        .wdog_hit    (hit[WDOG_CH]),
        .ien         (ien),
        .wdog_en     (wdog_en),
        .wdt_rst_req (wdt_rst_req)
    );

    assign irq = flag;

    always_comb begin
        unique case (dec.sel)
            SEL_MATCH:  rdata = match_val[dec.ch];
            SEL_COUNT:  rdata = cnt;
            SEL_STATUS: rdata = CNT_W'(flag);
            SEL_WDOG:   rdata = CNT_W'(wdog_en);
            SEL_IEN:    rdata = CNT_W'(ien);
            default:    rdata = '0;
        endcase
    end

    // R7: an interrupt line only falls on a status write
    p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) && !wr_status |=> ((irq & $past(irq)) == $past(irq)));

endmodule

// File: tb/ostmr_top_test.sv
module ostmr_top_test;
    import ostmr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic [NUM_CH-1:0] irq;
    logic              wdt_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ostmr_top uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
        .wdt_rst_req(wdt_rst_req)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
    localparam int NV = 18;
    // {op, offset, data (tick count for OP_TK), expected read}
    localparam logic [73:0] VEC [NV] = '{
        {OP_RD, 8'h10, 32'h0,        32'h0},        // R1 counter
        {OP_RD, 8'h14, 32'h0,        32'h0},        // R1 status
        {OP_RD, 8'h08, 32'h0,        32'h0},        // R1 compare
        {OP_WR, 8'h00, 32'h10,       32'h0},
        {OP_RD, 8'h00, 32'h0,        32'h10},       // R4
        {OP_WR, 8'h0C, 32'hCAFE0003, 32'h0},
        {OP_RD, 8'h0C, 32'h0,        32'hCAFE0003}, // R4
        {OP_WR, 8'h1C, 32'hFFFFF005, 32'h0},
        {OP_RD, 8'h1C, 32'h0,        32'h005},      // R8
        {OP_WR, 8'h10, 32'h0E,       32'h0},
        {OP_RD, 8'h10, 32'h0,        32'h0E},       // R3
        {OP_TK, 8'h00, 32'd2,        32'h0},
        {OP_RD, 8'h10, 32'h0,        32'h10},       // R2
        {OP_RD, 8'h14, 32'h0,        32'h1},        // R5
        {OP_WR, 8'h14, 32'h0,        32'h0},
        {OP_RD, 8'h14, 32'h0,        32'h1},        // R7 zero bits keep
        {OP_WR, 8'h14, 32'h1,        32'h0},
        {OP_RD, 8'h14, 32'h0,        32'h0}         // R7 cleared
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1 check(tag, rdata, exp);
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 wdt_rst_req", 32'(wdt_rst_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            {op, a, d, e} = VEC[i];
            case (op)
                OP_WR: wr(a, d);
                OP_RD: rd($sformatf("vector %0d (R1..R8 table)", i), a, e);
                default: tick(int'(d));
            endcase
        end

        // R6: channel 1 disabled (enable = 0x005)
        wr(8'h04, 32'h20);
        wr(8'h10, 32'h1F);
        tick(1);
        check("R6 irq", 32'(irq), 32'h0);
        rd("R6 status", 8'h14, 32'h0);

        // R5: enabled channel 0 raises its line
        wr(8'h00, 32'h21);
        tick(1);
        check("R5 irq", 32'(irq), 32'h1);
        wr(8'h14, 32'hF);
        check("R7 irq cleared", 32'(irq), 32'h0);

        // R9: watchdog with channel 3 interrupt disabled
        wr(8'h18, 32'h1);
        rd("R9 enable readback", 8'h18, 32'h1);
        wr(8'h0C, 32'h22);
        tick(1);
        check("R9 pulse", 32'(wdt_rst_req), 32'h1);
        @(negedge clk);
        check("R9 single cycle", 32'(wdt_rst_req), 32'h0);
        rd("R9 status bit3 stays 0", 8'h14, 32'h0);

        // R10: watchdog disabled
        wr(8'h18, 32'h0);
        wr(8'h0C, 32'h23);
        tick(1);
        check("R10 no pulse", 32'(wdt_rst_req), 32'h0);
        @(negedge clk);
        check("R10 no pulse later", 32'(wdt_rst_req), 32'h0);

        // R12: loading onto a compare value is no match
        wr(8'h10, 32'h21);
        @(negedge clk);
        rd("R12 status", 8'h14, 32'h0);
        check("R12 irq", 32'(irq), 32'h0);

        // R3: write beats a tick in the same cycle
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = 8'h10; wdata = 32'h500;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd("R3 priority", 8'h10, 32'h500);
        tick(3);
        rd("R3 continue", 8'h10, 32'h503);

        // R2: wrap
        wr(8'h10, 32'hFFFFFFFF);
        tick(1);
        rd("R2 wrap", 8'h10, 32'h0);

        // R11: undefined and unaligned offsets
        wr(8'h20, 32'hFFFFFFFF);
        wr(8'h02, 32'hFFFFFFFF);
        wr(8'h1E, 32'hFFFFFFFF);
        rd("R11 read undef", 8'h20, 32'h0);
        rd("R11 read unaligned", 8'h01, 32'h0);
        rd("R11 compare0 kept", 8'h00, 32'h21);
        rd("R11 enable kept", 8'h1C, 32'h005);
        rd("R11 counter kept", 8'h10, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule